// File: doc/BRIEF.md
# Cosine Tone Synthesizer

This block produces a stream of 8-bit unsigned codes for a DAC channel. The codes follow a cosine wave, and no sample memory is needed. A 16-bit phase register moves forward by a programmable step on every clock while the block runs. Its upper bits address a small table that holds one quarter of a cycle, and quadrant logic mirrors and negates the table output to build the full signed wave. The output frequency is therefore the step divided by 2^16, times the clock rate.

The signed wave then passes through three stages. A two-bit selector turns the starting phase by whole quarter turns. A two-bit attenuation halves the amplitude once for each step of its value. A signed offset moves the wave centre away from mid-scale. The final sum saturates at the two ends of the code range. While the block is stopped, the phase register is held at zero and the output rests at the centre level, which is mid-scale plus the offset.

Top module: `cos_tone_synth`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next output is `sample` = 128 with `sample_valid` low.
- R2: While `run` is high, the phase register grows by `step_word` on every clock, modulo 2^16. Sample k after a start (k = 0, 1, …) is computed from phase k·`step_word`. The first sample appears on the second rising edge after `run` is first sampled high.
- R3: The quadrant is phase bits [15:14] plus `phase_sel`, modulo 4. The table index i is bits [13:8]. The table entry is T(i) = floor(127·(65536 − 4u²)/(65536 + u²)) with u = 2i+1. The signed wave is +T(i), −T(63−i), −T(i) and +T(63−i) for quadrants 0, 1, 2 and 3.
- R4: `phase_sel` values 0, 1, 2 and 3 turn the wave by 0, 90, 180 and 270 degrees.
- R5: The signed wave is shifted arithmetically right by `atten` bits (0 to 3), so each step halves the peak-to-peak swing.
- R6: The output before saturation is 128 + `offset` (signed, −128 to 127) + the scaled wave. With zero offset the wave is centred at 128.
- R7: Sums above 255 give 255, and sums below 0 give 0. Values never wrap.
- R8: A low `run` clears the phase register. Two edges later `sample` = 128 + `offset`, and the level follows offset changes. A later start begins again at phase 0.
- R9: `sample_valid` is high exactly when `run` was high two rising edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Generator clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run | input | 1 | High to generate, low to stop and rest |
| step_word | input | 16 | Phase increment per clock |
| phase_sel | input | 2 | Starting phase in quarter turns |
| atten | input | 2 | Amplitude right-shift count |
| offset | input | 8 | Signed centre offset from mid-scale |
| sample | output | 8 | Unsigned output code |
| sample_valid | output | 1 | High while `sample` carries a live wave value |

## Verification
The properties assume that `rst_n` is synchronous and is held for at least one edge. They also assume that `offset`, `atten` and `phase_sel` act on the wave only through the two register stages, so the resting level can be predicted from the offset one edge back. The bench drives every input on the falling clock edge. It changes the wave configuration only while `run` is low, and it changes the offset on its own only while the block is stopped. As a result, each live sample maps to exactly one phase k·step. The saturation cases use offsets of +127 and −128 with full amplitude, so both clamp limits are reached.

// File: rtl/cts_pkg.sv
package cts_pkg;

   // Quarter-cycle cosine magnitude. The table is sampled at half-step
   // centres u = 2*idx+1 over a quarter of 2*depth half-steps, using a
   // rational approximation that needs integer arithmetic only.
   function automatic int quarter_cos(input int idx, input int depth, input int amp);
      longint u;
      longint full;
      longint num;
      longint den;
      u    = 2 * longint'(idx) + 1;
      full = 16 * longint'(depth) * longint'(depth);
      num  = full - 4 * u * u;
      den  = full + u * u;
      return int'((longint'(amp) * num) / den);
   endfunction

   // Signed value over a full cycle of 4*depth points, built from the quarter.
   function automatic int full_cos(input int k, input int depth, input int amp);
      int q;
      int i;
      q = (k / depth) % 4;
      i = k % depth;
      case (q)
         0:       return  quarter_cos(i, depth, amp);
         1:       return -quarter_cos(depth - 1 - i, depth, amp);
         2:       return -quarter_cos(i, depth, amp);
         default: return  quarter_cos(depth - 1 - i, depth, amp);
      endcase
   endfunction

endpackage

// File: rtl/cts_phase_acc.sv
module cts_phase_acc #(
   parameter int PH_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic [PH_W-1:0] step,
   output logic [PH_W-1:0] phase
);

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         phase <= '0;
      end else begin
         phase <= phase + step;
      end
   end

endmodule

// File: rtl/cts_wave_rom.sv
module cts_wave_rom #(
   parameter int ABITS = 6,
   parameter int AMP_W = 7
) (
   input  logic [ABITS-1:0] idx,
   output logic [AMP_W-1:0] mag
);
   import cts_pkg::*;

   localparam int DEPTH = 1 << ABITS;
   localparam int AMP   = (1 << AMP_W) - 1;

   logic [AMP_W-1:0] tbl [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_entry
      assign tbl[g] = AMP_W'(quarter_cos(g, DEPTH, AMP));
   end

   assign mag = tbl[idx];

endmodule

// File: rtl/cts_quadrant.sv
module cts_quadrant #(
   parameter int PH_W      = 16,
   parameter int ABITS     = 6,
   parameter int OUT_W     = 8,
   parameter bit QUARTER   = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    run,
   input  logic [PH_W-1:0]         phase,
   input  logic [1:0]              psel,
   output logic signed [OUT_W-1:0] wave,
   output logic                    live
);
   import cts_pkg::*;

   localparam int AMP_W = OUT_W - 1;
   localparam int DEPTH = 1 << ABITS;
   localparam int AMP   = (1 << AMP_W) - 1;

   logic [1:0]              quad;
   logic [ABITS-1:0]        raw_idx;
   logic signed [OUT_W-1:0] wave_d;

   assign quad    = phase[PH_W-1 -: 2] + psel;
   assign raw_idx = phase[PH_W-3 -: ABITS];

   if (QUARTER) begin : g_quarter
      logic [ABITS-1:0] rom_idx;
      logic [AMP_W-1:0] mag;
      logic             neg;

      assign rom_idx = quad[0] ? ~raw_idx : raw_idx;
      assign neg     = quad[0] ^ quad[1];

      cts_wave_rom #(.ABITS(ABITS), .AMP_W(AMP_W)) rom_i (
         .idx (rom_idx),
         .mag (mag)
      );

      always_comb begin
         if (neg) wave_d = -$signed({1'b0, mag});
         else     wave_d =  $signed({1'b0, mag});
      end
   end else begin : g_full
      logic signed [OUT_W-1:0] tbl [4*DEPTH];
      for (genvar g = 0; g < 4*DEPTH; g++) begin : g_entry
         assign tbl[g] = OUT_W'(full_cos(g, DEPTH, AMP));
      end
      assign wave_d = tbl[{quad, raw_idx}];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wave <= '0;
         live <= 1'b0;
      end else begin
         wave <= run ? wave_d : '0;
         live <= run;
      end
   end

endmodule

// File: rtl/cts_scale_sat.sv
module cts_scale_sat #(
   parameter int OUT_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    live,
   input  logic signed [OUT_W-1:0] wave,
   input  logic [1:0]              atten,
   input  logic signed [OUT_W-1:0] offset,
   output logic [OUT_W-1:0]        sample,
   output logic                    valid
);

   localparam int SUM_W = OUT_W + 3;
   localparam logic signed [SUM_W-1:0] MID_S = SUM_W'(1 << (OUT_W - 1));
   localparam logic signed [SUM_W-1:0] MAX_S = SUM_W'((1 << OUT_W) - 1);
   localparam logic [OUT_W-1:0]        MID_U = OUT_W'(1 << (OUT_W - 1));

   logic signed [OUT_W-1:0] scaled;
   logic signed [SUM_W-1:0] sum;
   logic [OUT_W-1:0]        clamped;

   always_comb begin
      scaled = wave >>> atten;
      sum    = MID_S + SUM_W'(offset) + SUM_W'(scaled);
      if (sum < 0)          clamped = '0;
      else if (sum > MAX_S) clamped = '1;
      else                  clamped = sum[OUT_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sample <= MID_U;
         valid  <= 1'b0;
      end else begin
         sample <= clamped;
         valid  <= live;
      end
   end

endmodule

// File: rtl/cos_tone_synth.sv
module cos_tone_synth #(
   parameter int PH_W      = 16,
   parameter int OUT_W     = 8,
   parameter int LUT_ABITS = 6,
   parameter bit QUARTER   = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    run,
   input  logic [PH_W-1:0]         step_word,
   input  logic [1:0]              phase_sel,
   input  logic [1:0]              atten,
   input  logic signed [OUT_W-1:0] offset,
   output logic [OUT_W-1:0]        sample,
   output logic                    sample_valid
);

   if (PH_W < LUT_ABITS + 2) begin : g_bad_phase_width
      $error("phase width must cover quadrant and table index bits");
   end
   if (OUT_W < 4) begin : g_bad_out_width
      $error("output width too small for the attenuation range");
   end
   if (LUT_ABITS < 2) begin : g_bad_table
      $error("table needs at least four entries");
   end

   logic [PH_W-1:0]         phase_q;
   logic signed [OUT_W-1:0] wave_q;
   logic                    live_q;

   cts_phase_acc #(.PH_W(PH_W)) acc_i (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .step  (step_word),
      .phase (phase_q)
   );

   cts_quadrant #(
      .PH_W    (PH_W),
      .ABITS   (LUT_ABITS),
      .OUT_W   (OUT_W),
      .QUARTER (QUARTER)
   ) quad_i (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .phase (phase_q),
      .psel  (phase_sel),
      .wave  (wave_q),
      .live  (live_q)
   );

   cts_scale_sat #(.OUT_W(OUT_W)) scale_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .live   (live_q),
      .wave   (wave_q),
      .atten  (atten),
      .offset (offset),
      .sample (sample),
      .valid  (sample_valid)
   );

endmodule

// File: rtl/cts_checks.sv
module cts_checks #(
   parameter int PH_W  = 16,
   parameter int OUT_W = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    run,
   input logic [PH_W-1:0]         step,
   input logic signed [OUT_W-1:0] offset,
   input logic [PH_W-1:0]         phase,
   input logic [OUT_W-1:0]        sample,
   input logic                    sample_valid
);

   localparam logic [OUT_W-1:0] MID = OUT_W'(1 << (OUT_W - 1));

   logic [1:0] since_rst;

   always_ff @(posedge clk) begin
      if (!rst_n)                 since_rst <= 2'd0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   p_reset_mid_r1: assert property (@(posedge clk)
      !rst_n |=> (sample == MID && !sample_valid));

   p_phase_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> phase == PH_W'($past(phase) + $past(step)));

   p_stop_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> phase == '0);

   p_valid_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 2'd2) |-> sample_valid == $past(run, 2));

   p_rest_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 2'd2 && !$past(run, 2)) |-> sample == ($past(offset) ^ MID));

endmodule

bind cos_tone_synth cts_checks #(.PH_W(PH_W), .OUT_W(OUT_W)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .run          (run),
   .step         (step_word),
   .offset       (offset),
   .phase        (phase_q),
   .sample       (sample),
   .sample_valid (sample_valid)
);

// File: tb/cos_tone_synth_tb_top.sv
`timescale 1ns/100ps
module cos_tone_synth_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       run = 1'b0;
   logic [15:0] step_word = '0;
   logic [1:0] phase_sel = '0;
   logic [1:0] atten = '0;
   logic [7:0] offset = '0;
   logic [7:0] sample;
   logic       sample_valid;

   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   cos_tone_synth dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .run          (run),
      .step_word    (step_word),
      .phase_sel    (phase_sel),
      .atten        (atten),
      .offset       (offset),
      .sample       (sample),
      .sample_valid (sample_valid)
   );

   // step, phase_sel, atten, offset
   localparam logic [27:0] VECS [6] = '{
      {16'h0100, 2'd0, 2'd0, 8'h00},
      {16'h1000, 2'd1, 2'd0, 8'h00},
      {16'h0C40, 2'd2, 2'd1, 8'hEC},
      {16'hF3C0, 2'd3, 2'd3, 8'h05},
      {16'h2100, 2'd0, 2'd0, 8'h7F},
      {16'h2100, 2'd2, 2'd0, 8'h80}
   };
   localparam int NSAMP = 12;

   function automatic int tmag(input int i);
      longint u;
      u = 2 * i + 1;
      return int'((127 * (65536 - 4 * u * u)) / (65536 + u * u));
   endfunction

   function automatic int clamp8(input int v);
      if (v < 0)   return 0;
      if (v > 255) return 255;
      return v;
   endfunction

   function automatic int model(input int ph, input int ps, input int at, input int off);
      int q;
      int i;
      int w;
      q = ((ph >> 14) + ps) & 3;
      i = (ph >> 8) & 63;
      case (q)
         0:       w =  tmag(i);
         1:       w = -tmag(63 - i);
         2:       w = -tmag(i);
         default: w =  tmag(63 - i);
      endcase
      return clamp8(128 + off + (w >>> at));
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #1000000;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      string tags [6] = '{"R3", "R4", "R5", "R2", "R7", "R7"};
      int off;

      // reset state (R1)
      edges(3);
      check("R1 sample", int'(sample), 128);
      check("R1 valid", int'(sample_valid), 0);
      rst_n = 1'b1;

      // vector table walk
      for (int v = 0; v < 6; v++) begin
         step_word = VECS[v][27:12];
         phase_sel = VECS[v][11:10];
         atten     = VECS[v][9:8];
         offset    = VECS[v][7:0];
         off       = int'($signed(offset));
         run       = 1'b1;
         @(posedge clk);
         for (int n = 0; n < NSAMP; n++) begin
            edges(1);
            check(tags[v], int'(sample),
                  model((n * int'(step_word)) & 16'hFFFF, int'(phase_sel), int'(atten), off));
            check("R9 valid high", int'(sample_valid), 1);
         end
         run = 1'b0;
         edges(2);
         check("R8 rest level", int'(sample), clamp8(128 + off));
         check("R9 valid low", int'(sample_valid), 0);
      end

      // R6: resting level follows offset while stopped
      offset = 8'hDB;
      edges(2);
      check("R6 offset -37", int'(sample), 91);
      offset = 8'h00;
      edges(2);
      check("R6 zero centre", int'(sample), 128);

      // R8: restart begins again at phase 0
      step_word = 16'h0500; phase_sel = 2'd0; atten = 2'd0;
      run = 1'b1;
      edges(6);
      run = 1'b0;
      edges(1);
      run = 1'b1;
      edges(2);
      check("R8 restart phase 0", int'(sample), model(0, 0, 0, 0));
      edges(1);
      check("R8 restart second", int'(sample), model(16'h0500, 0, 0, 0));

      // R1: reset during running
      rst_n = 1'b0;
      edges(1);
      check("R1 mid-run sample", int'(sample), 128);
      check("R1 mid-run valid", int'(sample_valid), 0);
      run = 1'b0;
      rst_n = 1'b1;
      edges(2);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule